// File: doc/BRIEF.md
# Latched Byte-Bus Target Interface

This block is the target end of a narrow expansion bus. The host has an 8-bit data path, a 3-bit register select and a load line. With them it fills a bank of eight byte-wide register slots. Four of the slots together hold a 32-bit transaction address. One slot holds the data byte, and the other three are unused. A rising edge on the host's write line or read line then starts one access. The access runs on the peripheral's local address bus, local data bus and local strobes. It can only start when bits 14..12 of the latched address name this block's slot, which is one of eight 4 KB windows.

Every access is held open for a fixed number of bus-clock cycles. That number is the bus clock rate divided by the target access rate, so a peripheral built from plain latches never has to meet tight timing. At the end of that count the block pulses its completion line for one cycle. After a read, the block drives the fetched byte back onto the shared data path until the host releases the read line. A host doing bursts only rewrites the low address byte and the data byte between accesses.

Top module: `lbb_target`

## Requirements
- R1: A load with select 0, 1, 2 or 3 stores `bus_din` into byte 0, 1, 2 or 3 of `loc_addr`, where byte 0 is bits 7..0. The new value shows on `loc_addr` one clock after the load edge.
- R2: A load with select 7 stores `bus_din` into the data register, which drives `loc_wdata` one clock later.
- R3: A load with select 4, 5 or 6 changes neither `loc_addr` nor `loc_wdata`. While the read result is driven, those selects return zero on `bus_dout`.
- R4: A rising edge of `bus_wr` while idle, with the slot matching, raises `loc_wr` from the next clock for exactly WAIT cycles, where WAIT = CLK_HZ/ACCESS_HZ. `bus_done` is high for the single cycle that follows. If both strobes rise together, the write wins.
- R5: A rising edge of `bus_rd` while idle, with the slot matching, raises `loc_rd` for WAIT cycles and captures `loc_rdata` into the data register as the access completes. `bus_doe` rises together with `bus_done`. `bus_dout` then shows the slot picked by `bus_sel`: address bytes for selects 0-3 and the data register for select 7.
- R6: `bus_doe` is low outside the window from read completion to the release of `bus_rd`, and `bus_dout` is zero whenever `bus_doe` is low. `bus_doe` falls one clock after `bus_rd` is seen low.
- R7: When the address does not match the slot, a strobe edge produces no local strobe, no `bus_done`, and no change to the data register.
- R8: A strobe edge that arrives while an access is pending, or during the read hold window, is ignored. A strobe held high across completion does not start another access.
- R9: Loads that arrive while an access is pending are ignored.
- R10: `bus_done` is never high for two cycles in a row, and `loc_wr` and `loc_rd` are never high together.
- R11: `loc_hit` is high exactly when bits 14..12 of `loc_addr` equal the SLOT_ID parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 3 | Register slot select |
| bus_din | input | 8 | Data path, host to target |
| bus_ld | input | 1 | Load the selected slot from `bus_din` |
| bus_wr | input | 1 | Write strobe, rising edge starts a write |
| bus_rd | input | 1 | Read strobe, rising edge starts a read |
| bus_dout | output | 8 | Data path, target to host |
| bus_doe | output | 1 | Target drives the shared data path |
| bus_done | output | 1 | One-cycle transaction-complete pulse |
| loc_addr | output | 32 | Latched local address |
| loc_wdata | output | 8 | Latched local write data |
| loc_rdata | input | 8 | Local read data from the peripheral |
| loc_wr | output | 1 | Local write strobe |
| loc_rd | output | 1 | Local read strobe |
| loc_hit | output | 1 | Latched address lies in this block's slot |

## Verification
Loads appear on `loc_addr` and `loc_wdata` one clock after the load edge, and the bench samples them at the next falling edge. A strobe is noticed at the first rising edge after it is driven. The local strobe is then high at the next WAIT falling edges, and `bus_done` and `bus_doe` are due exactly at the falling edge after those. The bench counts those edges one by one rather than waiting on a signal. The slot field and a range of address and data patterns are swept through writes and reads. During each read hold window the bench sweeps all eight selects, sampling `bus_dout` one time unit after changing the select, because the read-back path is combinational.

// File: rtl/lbb_pkg.sv
package lbb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WR   = 2'd1,
    ST_RD   = 2'd2,
    ST_HOLD = 2'd3
  } lbb_state_e;

  function automatic int pace_cycles(input int clk_hz, input int acc_hz);
    int c;
    c = clk_hz / acc_hz;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/lbb_latch_bank.sv
module lbb_latch_bank #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic              lock,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] din,
  input  logic              cap,
  input  logic [DATA_W-1:0] cap_data,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] rd_mux
);

  localparam int NB    = ADDR_W / DATA_W;
  localparam int NSLOT = 1 << SEL_W;
  localparam int DSLOT = NSLOT - 1;

  logic [DATA_W-1:0] abyte [NB];
  logic [DATA_W-1:0] data_q;
  logic              ld_ok;

  assign ld_ok = ld && !lock;

  for (genvar g = 0; g < NB; g++) begin : g_abyte
    always_ff @(posedge clk) begin
      if (rst) begin
        abyte[g] <= '0;
      end else if (ld_ok && sel == SEL_W'(g)) begin
        abyte[g] <= din;
      end
    end
    assign addr_o[g*DATA_W +: DATA_W] = abyte[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
    end else if (cap) begin
      data_q <= cap_data;
    end else if (ld_ok && sel == SEL_W'(DSLOT)) begin
      data_q <= din;
    end
  end

  assign data_o = data_q;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NB; i++) begin
      if (sel == SEL_W'(i)) rd_mux = abyte[i];
    end
    if (sel == SEL_W'(DSLOT)) rd_mux = data_q;
  end

  // R9
  locked_load_chk: assert property (@(posedge clk) disable iff (rst)
    (ld && lock) |=> $stable(addr_o));

  // R3
  reserved_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (ld && !cap && int'(sel) >= NB && int'(sel) != DSLOT)
      |=> ($stable(addr_o) && $stable(data_o)));

endmodule

// File: rtl/lbb_slot_decode.sv
module lbb_slot_decode #(
  parameter int SLOT_W  = 3,
  parameter int SLOT_ID = 0
) (
  input  logic [SLOT_W-1:0] field,
  output logic              hit
);

  localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(SLOT_ID);

  assign hit = (field == MY_SLOT);

endmodule

// File: rtl/lbb_pace_timer.sv
module lbb_pace_timer #(
  parameter int CYC = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic last
);

  localparam int CW = (CYC < 2) ? 1 : $clog2(CYC);
  localparam logic [CW-1:0] TERM = CW'(CYC - 1);

  logic [CW-1:0] cnt;
  logic          active;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (!active) begin
      if (start) begin
        cnt    <= '0;
        active <= 1'b1;
      end
    end else if (cnt == TERM) begin
      active <= 1'b0;
      cnt    <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign last = active && (cnt == TERM);

  // R4
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt <= TERM));

  // R4
  start_arms_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !active) |=> active);

endmodule

// File: rtl/lbb_seq.sv
module lbb_seq
  import lbb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bus_wr,
  input  logic bus_rd,
  input  logic hit,
  input  logic tmr_last,
  output logic tmr_start,
  output logic cap,
  output logic busy,
  output logic loc_wr,
  output logic loc_rd,
  output logic done,
  output logic doe
);

  lbb_state_e state;
  logic       wr_q, rd_q;
  logic       wr_rise, rd_rise;

  assign wr_rise   = bus_wr && !wr_q;
  assign rd_rise   = bus_rd && !rd_q;
  assign busy      = (state != ST_IDLE);
  assign tmr_start = (state == ST_IDLE) && hit && (wr_rise || rd_rise);
  assign cap       = (state == ST_RD) && tmr_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      loc_wr <= 1'b0;
      loc_rd <= 1'b0;
      done   <= 1'b0;
      doe    <= 1'b0;
    end else begin
      wr_q <= bus_wr;
      rd_q <= bus_rd;
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (hit && wr_rise) begin
            state  <= ST_WR;
            loc_wr <= 1'b1;
          end else if (hit && rd_rise) begin
            state  <= ST_RD;
            loc_rd <= 1'b1;
          end
        end
        ST_WR: begin
          if (tmr_last) begin
            loc_wr <= 1'b0;
            done   <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        ST_RD: begin
          if (tmr_last) begin
            loc_rd <= 1'b0;
            done   <= 1'b1;
            doe    <= 1'b1;
            state  <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (!bus_rd) begin
            doe   <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(loc_wr && loc_rd));

  // R4
  done_follows_access_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(loc_wr || loc_rd));

  // R6
  doe_release_chk: assert property (@(posedge clk) disable iff (rst)
    (doe && !bus_rd && !done) |=> !doe);

  // R7
  miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !hit) |=> !(loc_wr || loc_rd));

endmodule

// File: rtl/lbb_target.sv
module lbb_target
  import lbb_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SEL_W     = 3,
  parameter int ADDR_W    = 32,
  parameter int SLOT_LSB  = 12,
  parameter int SLOT_W    = 3,
  parameter int SLOT_ID   = 0,
  parameter int CLK_HZ    = 50_000_000,
  parameter int ACCESS_HZ = 1_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  bus_sel,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              bus_ld,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  output logic              bus_done,
  output logic [ADDR_W-1:0] loc_addr,
  output logic [DATA_W-1:0] loc_wdata,
  input  logic [DATA_W-1:0] loc_rdata,
  output logic              loc_wr,
  output logic              loc_rd,
  output logic              loc_hit
);

  localparam int WAIT_CYC = pace_cycles(CLK_HZ, ACCESS_HZ);

  logic              busy, cap, tmr_start, tmr_last, hit;
  logic [DATA_W-1:0] rd_mux;

  lbb_latch_bank #(
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W),
    .ADDR_W (ADDR_W)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .ld       (bus_ld),
    .lock     (busy),
    .sel      (bus_sel),
    .din      (bus_din),
    .cap      (cap),
    .cap_data (loc_rdata),
    .addr_o   (loc_addr),
    .data_o   (loc_wdata),
    .rd_mux   (rd_mux)
  );

  lbb_slot_decode #(
    .SLOT_W  (SLOT_W),
    .SLOT_ID (SLOT_ID)
  ) u_dec (
    .field (loc_addr[SLOT_LSB +: SLOT_W]),
    .hit   (hit)
  );

  lbb_pace_timer #(
    .CYC (WAIT_CYC)
  ) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .start (tmr_start),
    .last  (tmr_last)
  );

  lbb_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .hit       (hit),
    .tmr_last  (tmr_last),
    .tmr_start (tmr_start),
    .cap       (cap),
    .busy      (busy),
    .loc_wr    (loc_wr),
    .loc_rd    (loc_rd),
    .done      (bus_done),
    .doe       (bus_doe)
  );

  assign bus_dout = bus_doe ? rd_mux : '0;
  assign loc_hit  = hit;

  // R6
  dout_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_doe |-> (bus_dout == '0));

endmodule

// File: tb/lbb_target_test.sv
module lbb_target_test;

  localparam int PERIOD  = 10;
  localparam int W       = 4;
  localparam int MY_SLOT = 5;

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] bus_sel;
  logic [7:0] bus_din;
  logic       bus_ld, bus_wr, bus_rd;
  logic [7:0] bus_dout;
  logic       bus_doe, bus_done;
  logic [31:0] loc_addr;
  logic [7:0] loc_wdata, loc_rdata;
  logic       loc_wr, loc_rd, loc_hit;

  int tests = 0;
  int fails = 0;
  logic [7:0] cur_data = 8'h00;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  // peripheral model: read data is a function of the address
  assign loc_rdata = loc_addr[7:0] ^ loc_addr[15:8] ^ 8'h3C;

  lbb_target #(
    .SLOT_ID   (MY_SLOT),
    .CLK_HZ    (4_000_000),
    .ACCESS_HZ (1_000_000)
  ) uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_din(bus_din), .bus_ld(bus_ld),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .bus_done(bus_done), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
    .loc_rdata(loc_rdata), .loc_wr(loc_wr), .loc_rd(loc_rd), .loc_hit(loc_hit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load_byte(input logic [2:0] s, input logic [7:0] v);
    @(negedge clk);
    bus_sel = s; bus_din = v; bus_ld = 1'b1;
    @(negedge clk);
    bus_ld = 1'b0;
  endtask

  task automatic load_addr(input logic [31:0] a);
    for (int i = 0; i < 4; i++) load_byte(3'(i), a[8*i +: 8]);
    check("R1 loc_addr", loc_addr, a);
  endtask

  function automatic logic in_slot(input logic [31:0] a);
    return a[14:12] == 3'(MY_SLOT);
  endfunction

  task automatic do_write(input logic [31:0] a, input logic [7:0] d);
    logic h;
    load_addr(a);
    load_byte(3'd7, d);
    cur_data = d;
    h = in_slot(a);
    check("R2 loc_wdata", loc_wdata, d);
    check("R11 loc_hit", loc_hit, h);
    bus_wr = 1'b1;
    for (int k = 1; k <= W; k++) begin
      @(negedge clk);
      check(h ? "R4 loc_wr during access" : "R7 loc_wr on miss", loc_wr, h);
      check("R4 done early", bus_done, 1'b0);
    end
    @(negedge clk);
    check(h ? "R4 done at completion" : "R7 done on miss", bus_done, h);
    check("R4 loc_wr after completion", loc_wr, 1'b0);
    bus_wr = 1'b0;
    @(negedge clk);
    check("R10 done single cycle", bus_done, 1'b0);
  endtask

  task automatic do_read(input logic [31:0] a);
    logic h;
    logic [7:0] exp;
    load_addr(a);
    h = in_slot(a);
    if (h) cur_data = a[7:0] ^ a[15:8] ^ 8'h3C;
    bus_sel = 3'd7;
    bus_rd = 1'b1;
    for (int k = 1; k <= W; k++) begin
      @(negedge clk);
      check(h ? "R5 loc_rd during access" : "R7 loc_rd on miss", loc_rd, h);
      check("R6 doe before completion", bus_doe, 1'b0);
    end
    @(negedge clk);
    check(h ? "R5 done at completion" : "R7 done on miss", bus_done, h);
    check("R5 doe at completion", bus_doe, h);
    for (int s = 0; s < 8; s++) begin
      bus_sel = 3'(s);
      #1;
      if (!h)              exp = 8'h00;
      else if (s < 4)      exp = a[8*s +: 8];
      else if (s == 7)     exp = cur_data;
      else                 exp = 8'h00;
      check((s >= 4 && s <= 6) ? "R3 reserved read" : (h ? "R5 dout" : "R6 dout idle"),
            bus_dout, exp);
    end
    check("R7 data register kept", loc_wdata, cur_data);
    @(negedge clk);
    check("R6 doe held while rd high", bus_doe, h);
    bus_rd = 1'b0;
    @(negedge clk);
    check("R6 doe after release", bus_doe, 1'b0);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    rst = 1'b1; bus_sel = '0; bus_din = '0; bus_ld = 0; bus_wr = 0; bus_rd = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset addr", loc_addr, 32'h0);
    check("R6 reset doe", bus_doe, 1'b0);
    check("R10 reset done", bus_done, 1'b0);
    check("R4 reset loc_wr", loc_wr, 1'b0);

    // slot sweep with writes and reads
    for (int s = 0; s < 8; s++) begin
      a = 32'hA000_0000 | (32'(s) << 12) | (32'(s) * 32'h0001_0111);
      do_write(a, 8'(8'h11 * s + 3));
      do_read(a ^ 32'h0000_00F0);
    end

    // reserved slots ignored
    a = 32'h1234_5ABC;
    load_addr(a);
    load_byte(3'd7, 8'h5A);
    cur_data = 8'h5A;
    for (int s = 4; s < 7; s++) load_byte(3'(s), 8'hFF);
    check("R3 addr after reserved loads", loc_addr, a);
    check("R3 data after reserved loads", loc_wdata, 8'h5A);

    // burst: only low byte changes
    for (int b = 0; b < 4; b++) begin
      a = 32'h0000_5000 | 32'(b);
      do_write(a, 8'(8'hC0 + b));
    end

    // pending strobe and load are ignored
    a = 32'h0000_5077;
    load_addr(a);
    bus_wr = 1'b1;
    @(negedge clk);
    check("R4 loc_wr start", loc_wr, 1'b1);
    @(negedge clk);
    bus_wr = 1'b0;
    @(negedge clk);
    bus_wr = 1'b1; bus_ld = 1'b1; bus_sel = 3'd0; bus_din = 8'hEE;
    @(negedge clk);
    bus_ld = 1'b0;
    check("R8 done not yet", bus_done, 1'b0);
    @(negedge clk);
    check("R8 done once", bus_done, 1'b1);
    for (int k = 0; k < 2 * W; k++) begin
      @(negedge clk);
      check("R8 no second access", loc_wr, 1'b0);
      check("R8 no second done", bus_done, 1'b0);
    end
    check("R9 load while busy ignored", loc_addr, a);
    bus_wr = 1'b0;

    // simultaneous rise: write wins
    @(negedge clk);
    bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    check("R4 write priority wr", loc_wr, 1'b1);
    check("R10 write priority rd", loc_rd, 1'b0);
    repeat (W) @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    @(negedge clk);
    check("R6 no doe after write", bus_doe, 1'b0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule